// File: doc/BRIEF.md
# Selector Access Rights Verifier

This block judges whether a 16-bit segment selector may be used from the current privilege level. It serves three query kinds: one returns the access-rights word of the descriptor, one asks whether the segment may be read, and one asks whether it may be written. The caller supplies the selector, the two-bit current privilege level, the query kind, an operand-size flag, the high 32-bit word of the descriptor the selector names, and a flag that tells whether that descriptor lies inside its table. Fetching the descriptor, raising faults and writing the result to a register stay with the caller.

A one-cycle request strobe qualifies the inputs. One clock later the block raises a one-cycle done pulse and presents a zero-flag verdict (set means the selector is usable for that query) together with the rights word. Between requests the outputs keep their last values.

Top module: `selrights_check`

## Requirements
- R1: A selector whose bits 15:2 are all zero is null and every query on it gives zero-flag clear; a selector with only bit 2 set is not null.
- R2: When the in-table flag is low the result is zero-flag clear for every query kind.
- R3: Descriptor high word fields: privilege level in bits 14:13, code/data flag in bit 12 (1 = code or data, 0 = system), type in bits 11:8 with bit 11 executable, bit 10 conforming or expand-down, bit 9 readable or writable. The privilege check fails when the descriptor level is numerically below the current level or below the selector's requested level (bits 1:0); a failed check gives zero-flag clear.
- R4: For the rights query on a code or data descriptor, the privilege check is skipped only when the descriptor is both executable and conforming; expand-down data still gets the check.
- R5: For the rights query on a system descriptor, only types 1, 2, 3, 4, 5, 9, 11 and 12 are accepted and must then pass the privilege check; any other type gives zero-flag clear.
- R6: On a granted rights query the rights output is the high descriptor word ANDed with 0x00FFFF00 when the wide flag is 1, and ANDed with 0x0000FF00 when it is 0.
- R7: The readable query rejects system descriptors and code without the readable bit, grants readable conforming code without a privilege check, and grants readable non-conforming code and any data segment only if the privilege check passes.
- R8: The writable query rejects system descriptors and every code segment, and grants a data segment only when it is writable and passes the privilege check.
- R9: After a request strobe the done output pulses high for exactly one cycle on the next clock, with the verdict; without a strobe done stays low and the verdict and rights hold. Reset clears done, verdict and rights.
- R10: Query kind encoding: 0 rights, 1 readable, 2 writable; kind 3 always gives zero-flag clear.
- R11: The rights output is zero whenever the verdict is clear or the query kind is not the rights query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_sel | input | 16 | Segment selector under test |
| req_cpl | input | 2 | Current privilege level |
| req_kind | input | 2 | Query kind (0 rights, 1 readable, 2 writable, 3 reserved) |
| req_wide | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| req_in_table | input | 1 | Descriptor lies inside its table |
| req_desc_hi | input | 32 | High word of the descriptor |
| rsp_done | output | 1 | One-cycle result pulse |
| rsp_zf | output | 1 | Verdict: 1 = usable for the query |
| rsp_rights | output | 32 | Masked rights word (rights query only) |

## Verification
The hardest situations are those where only one of the two privilege comparisons fails, because a design that checks just one of them looks correct in most cases. The stimulus table therefore places the descriptor level between the current level and the requested level in both directions, and pairs conforming code with expand-down data, which share the same type bit but differ in whether the check is bypassed. Descriptor words carry nonzero filler outside the decoded fields so that a wrong mask width shows up in the rights output.

// File: rtl/selrights_pkg.sv
package selrights_pkg;

    localparam int SEL_W  = 16;
    localparam int PL_W   = 2;
    localparam int WORD_W = 32;
    localparam int TYP_W  = 4;
    localparam int FLD_W  = PL_W + 1 + TYP_W;   // descriptor bits 14:8

    typedef enum logic [1:0] {
        Q_RIGHTS = 2'd0,
        Q_READ   = 2'd1,
        Q_WRITE  = 2'd2,
        Q_RSVD   = 2'd3
    } query_e;

    typedef struct packed {
        logic [PL_W-1:0]  dpl;
        logic             is_seg;
        logic             exec;
        logic             conf;
        logic             rw;
        logic [TYP_W-1:0] typ;
    } desc_f_t;

    // system types accepted by the rights query: 1,2,3,4,5,9,11,12
    localparam logic [(1<<TYP_W)-1:0] SYS_ACCEPT = 16'h1A3E;

    localparam logic [WORD_W-1:0] MASK_WIDE   = 32'h00FF_FF00;
    localparam logic [WORD_W-1:0] MASK_NARROW = 32'h0000_FF00;

    function automatic desc_f_t split_fields(logic [FLD_W-1:0] f);
        desc_f_t d;
        d.dpl    = f[FLD_W-1 -: PL_W];
        d.is_seg = f[TYP_W];
        d.typ    = f[TYP_W-1:0];
        d.exec   = f[3];
        d.conf   = f[2];
        d.rw     = f[1];
        return d;
    endfunction

    function automatic logic level_ok(logic [PL_W-1:0] dpl,
                                      logic [PL_W-1:0] cpl,
                                      logic [PL_W-1:0] rpl);
        return (dpl >= cpl) && (dpl >= rpl);
    endfunction

endpackage

// File: rtl/selrights_decode.sv
module selrights_decode
    import selrights_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [FLD_W-1:0] hi_fields,
    output desc_f_t          fields,
    output logic             sel_null,
    output logic [PL_W-1:0]  rpl
);
    always_comb begin
        fields   = split_fields(hi_fields);
        sel_null = (sel[SEL_W-1:2] == '0);
        rpl      = sel[PL_W-1:0];
    end
endmodule

// File: rtl/selrights_judge.sv
module selrights_judge
    import selrights_pkg::*;
(
    input  desc_f_t         fields,
    input  logic [1:0]      kind,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] rpl,
    input  logic            sel_null,
    input  logic            in_table,
    output logic            grant,
    output logic            rights_grant
);
    logic   lvl;
    logic   ok;
    query_e q;

    always_comb begin
        q   = query_e'(kind);
        lvl = level_ok(fields.dpl, cpl, rpl);
        ok  = 1'b0;
        unique case (q)
            Q_RIGHTS: begin
                if (fields.is_seg)
                    ok = (fields.exec && fields.conf) || lvl;
                else
                    ok = SYS_ACCEPT[fields.typ] && lvl;
            end
            Q_READ: begin
                if (!fields.is_seg)
                    ok = 1'b0;
                else if (fields.exec)
                    ok = fields.rw && (fields.conf || lvl);
                else
                    ok = lvl;
            end
            Q_WRITE: begin
                ok = fields.is_seg && !fields.exec && fields.rw && lvl;
            end
            default: ok = 1'b0;
        endcase
        grant        = ok && !sel_null && in_table;
        rights_grant = grant && (q == Q_RIGHTS);
    end
endmodule

// File: rtl/selrights_mask.sv
module selrights_mask
    import selrights_pkg::*;
(
    input  logic [WORD_W-1:0] hi,
    input  logic              wide,
    input  logic              enable,
    output logic [WORD_W-1:0] rights
);
    always_comb begin
        if (!enable)
            rights = '0;
        else if (wide)
            rights = hi & MASK_WIDE;
        else
            rights = hi & MASK_NARROW;
    end
endmodule

// File: rtl/selrights_check.sv
module selrights_check
    import selrights_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [15:0]       req_sel,
    input  logic [1:0]        req_cpl,
    input  logic [1:0]        req_kind,
    input  logic              req_wide,
    input  logic              req_in_table,
    input  logic [31:0]       req_desc_hi,
    output logic              rsp_done,
    output logic              rsp_zf,
    output logic [31:0]       rsp_rights
);
    desc_f_t           fields;
    logic              sel_null;
    logic [PL_W-1:0]   rpl;
    logic              grant;
    logic              rights_grant;
    logic [WORD_W-1:0] rights_nxt;

    selrights_decode u_decode (
        .sel       (req_sel),
        .hi_fields (req_desc_hi[FLD_W+7:8]),
        .fields    (fields),
        .sel_null  (sel_null),
        .rpl       (rpl)
    );

    selrights_judge u_judge (
        .fields       (fields),
        .kind         (req_kind),
        .cpl          (req_cpl),
        .rpl          (rpl),
        .sel_null     (sel_null),
        .in_table     (req_in_table),
        .grant        (grant),
        .rights_grant (rights_grant)
    );

    selrights_mask u_mask (
        .hi     (req_desc_hi),
        .wide   (req_wide),
        .enable (rights_grant),
        .rights (rights_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done   <= 1'b0;
            rsp_zf     <= 1'b0;
            rsp_rights <= '0;
        end else begin
            rsp_done <= req_valid;
            if (req_valid) begin
                rsp_zf     <= grant;
                rsp_rights <= rights_nxt;
            end
        end
    end
endmodule

// File: rtl/selrights_chk.sv
module selrights_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [15:0] req_sel,
    input logic [1:0]  req_kind,
    input logic        req_wide,
    input logic        req_in_table,
    input logic [31:0] req_desc_hi,
    input logic        rsp_done,
    input logic        rsp_zf,
    input logic [31:0] rsp_rights
);
    p_null_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ((req_sel >> 2) == 16'h0)) |=> !rsp_zf);

    p_outside_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_in_table) |=> !rsp_zf);

    p_wide_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0 && req_wide) |=>
        (rsp_rights == 32'h0 || rsp_rights == ($past(req_desc_hi) & 32'h00FF_FF00)));

    p_narrow_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0 && !req_wide) |=>
        (rsp_rights[31:16] == 16'h0 && rsp_rights[7:0] == 8'h0));

    p_write_no_code_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2 && (!req_desc_hi[12] || req_desc_hi[11])) |=> !rsp_zf);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_done && $stable(rsp_zf) && $stable(rsp_rights)));

    p_rsvd_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd3) |=> !rsp_zf);

    p_rights_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !rsp_zf) |-> rsp_rights == 32'h0);
endmodule

bind selrights_check selrights_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_sel      (req_sel),
    .req_kind     (req_kind),
    .req_wide     (req_wide),
    .req_in_table (req_in_table),
    .req_desc_hi  (req_desc_hi),
    .rsp_done     (rsp_done),
    .rsp_zf       (rsp_zf),
    .rsp_rights   (rsp_rights)
);

// File: tb/tb_selrights_check.sv
module tb_selrights_check;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [15:0] req_sel;
    logic [1:0]  req_cpl;
    logic [1:0]  req_kind;
    logic        req_wide;
    logic        req_in_table;
    logic [31:0] req_desc_hi;
    logic        rsp_done;
    logic        rsp_zf;
    logic [31:0] rsp_rights;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    selrights_check dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_cpl(req_cpl), .req_kind(req_kind), .req_wide(req_wide),
        .req_in_table(req_in_table), .req_desc_hi(req_desc_hi),
        .rsp_done(rsp_done), .rsp_zf(rsp_zf), .rsp_rights(rsp_rights)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] sel;
        logic [1:0]  cpl;
        logic        wide;
        logic        intab;
        logic [1:0]  dpl;
        logic        s;
        logic [3:0]  typ;
        logic        exp_zf;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 44;
    // selectors: 0008 rpl0, 000B rpl3, 0009 rpl1, 0000/0003 null, 0004 only bit 2
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h0008, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 4'h2, 1'b1, 8'd6},  // R6 wide data
        '{2'd0, 16'h0008, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1, 4'h2, 1'b1, 8'd6},  // R6 narrow data
        '{2'd0, 16'h000B, 2'd3, 1'b0, 1'b1, 2'd3, 1'b1, 4'hA, 1'b1, 8'd6},  // R6 narrow code
        '{2'd0, 16'h0008, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 4'h2, 1'b0, 8'd3},  // R3 dpl<cpl
        '{2'd0, 16'h000B, 2'd0, 1'b1, 1'b1, 2'd1, 1'b1, 4'h2, 1'b0, 8'd3},  // R3 dpl<rpl
        '{2'd0, 16'h0009, 2'd2, 1'b1, 1'b1, 2'd1, 1'b1, 4'h2, 1'b0, 8'd3},  // R3 cpl>dpl=rpl
        '{2'd0, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 4'h0, 1'b1, 8'd3},  // R3 equal levels
        '{2'd0, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 4'hC, 1'b1, 8'd4},  // R4 conforming exec-only
        '{2'd0, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 4'hE, 1'b1, 8'd4},  // R4 conforming readable
        '{2'd0, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 4'h6, 1'b0, 8'd4},  // R4 expand-down data
        '{2'd0, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 4'hA, 1'b0, 8'd4},  // R4 nonconforming code
        '{2'd0, 16'h0008, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 4'h1, 1'b1, 8'd5},  // R5 type 1
        '{2'd0, 16'h0008, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 4'h5, 1'b1, 8'd5},  // R5 type 5
        '{2'd0, 16'h0008, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 4'h9, 1'b1, 8'd5},  // R5 type 9
        '{2'd0, 16'h0008, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 4'hB, 1'b1, 8'd5},  // R5 type 11
        '{2'd0, 16'h0008, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 4'hC, 1'b1, 8'd5},  // R5 type 12
        '{2'd0, 16'h0008, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 4'h0, 1'b0, 8'd5},  // R5 type 0
        '{2'd0, 16'h0008, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 4'h6, 1'b0, 8'd5},  // R5 type 6
        '{2'd0, 16'h0008, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 4'hE, 1'b0, 8'd5},  // R5 type 14
        '{2'd0, 16'h0008, 2'd3, 1'b1, 1'b1, 2'd0, 1'b0, 4'h2, 1'b0, 8'd5},  // R5 system priv fail
        '{2'd1, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 4'hE, 1'b1, 8'd7},  // R7 readable conforming
        '{2'd1, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 4'hC, 1'b0, 8'd7},  // R7 exec-only conforming
        '{2'd1, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 4'hA, 1'b0, 8'd7},  // R7 code priv fail
        '{2'd1, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 4'hA, 1'b1, 8'd7},  // R7 code priv pass
        '{2'd1, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 4'h8, 1'b0, 8'd7},  // R7 exec-only code
        '{2'd1, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 4'h0, 1'b1, 8'd7},  // R7 read-only data
        '{2'd1, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 4'h2, 1'b0, 8'd7},  // R7 data priv fail
        '{2'd1, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b0, 4'h2, 1'b0, 8'd7},  // R7 system
        '{2'd2, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 4'h2, 1'b1, 8'd8},  // R8 writable data
        '{2'd2, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 4'h0, 1'b0, 8'd8},  // R8 read-only data
        '{2'd2, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 4'hA, 1'b0, 8'd8},  // R8 code
        '{2'd2, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 4'hE, 1'b0, 8'd8},  // R8 conforming code
        '{2'd2, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd3, 1'b0, 4'h2, 1'b0, 8'd8},  // R8 system
        '{2'd2, 16'h000B, 2'd3, 1'b1, 1'b1, 2'd2, 1'b1, 4'h2, 1'b0, 8'd8},  // R8 priv fail
        '{2'd2, 16'h000B, 2'd0, 1'b1, 1'b1, 2'd3, 1'b1, 4'h6, 1'b1, 8'd8},  // R8 expand-down writable
        '{2'd0, 16'h0000, 2'd0, 1'b1, 1'b1, 2'd3, 1'b1, 4'h2, 1'b0, 8'd1},  // R1 null rights
        '{2'd1, 16'h0003, 2'd0, 1'b1, 1'b1, 2'd3, 1'b1, 4'h2, 1'b0, 8'd1},  // R1 null readable
        '{2'd2, 16'h0000, 2'd0, 1'b1, 1'b1, 2'd3, 1'b1, 4'h2, 1'b0, 8'd1},  // R1 null writable
        '{2'd2, 16'h0004, 2'd0, 1'b1, 1'b1, 2'd3, 1'b1, 4'h2, 1'b1, 8'd1},  // R1 bit 2 only
        '{2'd0, 16'h0008, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 4'h2, 1'b0, 8'd2},  // R2 rights
        '{2'd1, 16'h0008, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 4'h2, 1'b0, 8'd2},  // R2 readable
        '{2'd2, 16'h0008, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 4'h2, 1'b0, 8'd2},  // R2 writable
        '{2'd3, 16'h0008, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 4'h2, 1'b0, 8'd10}, // R10 reserved kind
        '{2'd3, 16'h0008, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 4'h1, 1'b0, 8'd10}  // R10 reserved kind
    };

    function automatic logic [31:0] mk_hi(logic [1:0] dpl, logic s, logic [3:0] typ);
        return {16'hC35A, 1'b0, dpl, s, typ, 8'h7E};
    endfunction

    function automatic logic [31:0] exp_rights(logic [1:0] kind, logic wide,
                                               logic zf, logic [31:0] hi);
        if (!zf || kind != 2'd0) return 32'h0;                   // R11
        return wide ? (hi & 32'h00FF_FF00) : (hi & 32'h0000_FF00); // R6
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic drive(input logic [1:0] kind, input logic [15:0] sel,
                         input logic [1:0] cpl, input logic wide,
                         input logic intab, input logic [31:0] hi);
        req_kind = kind; req_sel = sel; req_cpl = cpl; req_wide = wide;
        req_in_table = intab; req_desc_hi = hi;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        drive(2'd0, 16'h0, 2'd0, 1'b0, 1'b0, 32'h0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        check(rsp_done == 1'b0, "R9 reset done", {31'h0, rsp_done}, 32'h0);
        check(rsp_zf == 1'b0, "R9 reset zf", {31'h0, rsp_zf}, 32'h0);
        check(rsp_rights == 32'h0, "R9 reset rights", rsp_rights, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] hi;
            logic [31:0] er;
            string tag;
            hi = mk_hi(VECS[i].dpl, VECS[i].s, VECS[i].typ);
            er = exp_rights(VECS[i].kind, VECS[i].wide, VECS[i].exp_zf, hi);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            @(negedge clk);
            drive(VECS[i].kind, VECS[i].sel, VECS[i].cpl, VECS[i].wide,
                  VECS[i].intab, hi);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check(rsp_done == 1'b1, {tag, " done R9"}, {31'h0, rsp_done}, 32'h1);
            check(rsp_zf == VECS[i].exp_zf, {tag, " zf"}, {31'h0, rsp_zf},
                  {31'h0, VECS[i].exp_zf});
            check(rsp_rights == er, {tag, " rights R11"}, rsp_rights, er);
        end

        // R9 hold: a granted wide rights result, then idle cycles with other inputs
        @(negedge clk);
        drive(2'd0, 16'h000B, 2'd3, 1'b1, 1'b1, mk_hi(2'd3, 1'b1, 4'h2));
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_zf == 1'b1, "R9 hold setup zf", {31'h0, rsp_zf}, 32'h1);
        drive(2'd0, 16'h0000, 2'd0, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        check(rsp_done == 1'b0, "R9 idle done", {31'h0, rsp_done}, 32'h0);
        check(rsp_zf == 1'b1, "R9 idle zf hold", {31'h0, rsp_zf}, 32'h1);
        check(rsp_rights == (mk_hi(2'd3, 1'b1, 4'h2) & 32'h00FF_FF00), "R9 idle rights hold",
              rsp_rights, mk_hi(2'd3, 1'b1, 4'h2) & 32'h00FF_FF00);
        @(negedge clk);
        check(rsp_zf == 1'b1, "R9 second idle zf hold", {31'h0, rsp_zf}, 32'h1);

        // R9 back-to-back strobes: done stays high, results follow each request
        drive(2'd2, 16'h000B, 2'd3, 1'b1, 1'b1, mk_hi(2'd3, 1'b1, 4'h2));
        req_valid = 1'b1;
        @(negedge clk);
        check(rsp_zf == 1'b1 && rsp_rights == 32'h0, "R11 writable grant no rights",
              rsp_rights, 32'h0);
        drive(2'd2, 16'h000B, 2'd3, 1'b1, 1'b1, mk_hi(2'd3, 1'b1, 4'hA));
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_done == 1'b1, "R9 back-to-back done", {31'h0, rsp_done}, 32'h1);
        check(rsp_zf == 1'b0, "R8 back-to-back code", {31'h0, rsp_zf}, 32'h0);

        // R9 reset clears a held grant
        drive(2'd0, 16'h0008, 2'd0, 1'b1, 1'b1, mk_hi(2'd0, 1'b1, 4'h2));
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(rsp_zf == 1'b0 && rsp_rights == 32'h0 && rsp_done == 1'b0,
              "R9 reset after grant", rsp_rights, 32'h0);

        summary();
        $finish;
    end
endmodule